// File: doc/BRIEF.md
# Kernel Completion and Counter Tracker

This block keeps a small table with one entry per kernel slot. An entry holds the workgroup total and several live counters: outstanding cache invalidates, outstanding writebacks and completed workgroups. Other agents send single-step counter updates and workgroup-completion events. The block reports per-slot invalidate idleness, answers writeback updates with a "now drained" flag, and answers a look-ahead query that says whether the next workgroup to finish will be the last one for a kernel.

When the final workgroup of a kernel completes, the block emits a completion pulse that carries the kernel's packet handle and queue number, and it frees the slot. If the kernel was allocated with a non-zero signal address, the block then decrements the 64-bit value at that address in memory. It does this with a read followed by a write on a simple request/response port. New workgroup completions are refused while that sequence is outstanding. Invalidates draining to zero and accepted workgroup completions both raise a dispatch-scheduling request. A new request is issued only when none is already pending, and a pending request stays pending until the scheduler acknowledges it.

Top module: `kern_track`

## Requirements
- R1: Counter updates on the invalidate and writeback ports carry a 2-bit step code: 2'b01 adds one, 2'b11 subtracts one. Codes 2'b00 and 2'b10, a decrement of a zero count and an increment of a full count are errors and change no count.
- R2: Bit k of `inv_idle` is high exactly when slot k is allocated and its outstanding-invalidate count is zero. It reflects an update one cycle after the update is presented.
- R3: A dispatch-scheduling trigger is either an invalidate decrement that brings a count to zero or an accepted workgroup completion. On a trigger, `sched_req` pulses one cycle later, but only if no request is pending (a `sched_ack` in the same cycle clears the pending state first). `sched_pend` stays high from the trigger until `sched_ack`.
- R4: An accepted writeback update produces `wb_rsp_vld` one cycle later. `wb_rsp_zero` is high exactly when the updated writeback count is zero.
- R5: `last_wg` is combinational and is high when slot `query_id` is allocated and its completed count plus one equals its total. For a free slot it is low.
- R6: Each accepted workgroup completion on an allocated slot that is not the last one increments that slot's completed count.
- R7: When the completed count reaches the total, `kern_done` pulses one cycle later with the slot's packet handle and queue number, and the slot is freed.
- R8: For a finished kernel with a non-zero signal address, the block issues a read at that address. It then issues a write of the returned value minus one to the same address. A request is held stable until `mem_req_rdy`. A zero signal address produces no memory request.
- R9: `wg_done_rdy` is low from the `kern_done` pulse that starts a decrement sequence until that sequence's write is accepted. A completion presented while it is low is ignored.
- R10: An operation on a free slot, an allocation of an allocated slot or with a zero total, and any R1 error set the sticky `err` output and leave the table unchanged. Only reset clears `err`.
- R11: After reset no slot is allocated, `err`, `sched_req`, `sched_pend`, `kern_done` and `mem_req_vld` are low, and `wg_done_rdy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_vld | input | 1 | Allocate a slot |
| alloc_id | input | IDW | Slot to allocate |
| alloc_wg_total | input | WGW | Workgroup total of the kernel |
| alloc_sig_addr | input | AW | Completion-signal address, zero for none |
| alloc_pkt | input | PW | Packet handle reported at completion |
| alloc_qid | input | QW | Queue number reported at completion |
| inv_vld | input | 1 | Invalidate-counter update |
| inv_id | input | IDW | Slot of the invalidate update |
| inv_code | input | 2 | Step code (R1) |
| wb_vld | input | 1 | Writeback-counter update |
| wb_id | input | IDW | Slot of the writeback update |
| wb_code | input | 2 | Step code (R1) |
| wb_rsp_vld | output | 1 | Writeback update response |
| wb_rsp_zero | output | 1 | Writeback count drained |
| query_id | input | IDW | Slot for the last-workgroup query |
| last_wg | output | 1 | Next completion will finish the kernel |
| wg_done_vld | input | 1 | Workgroup completion event |
| wg_done_id | input | IDW | Slot of the completion |
| wg_done_rdy | output | 1 | Completions are accepted |
| inv_idle | output | NK | Per-slot invalidates drained |
| sched_req | output | 1 | Dispatch-scheduling request pulse |
| sched_pend | output | 1 | A scheduling request is pending |
| sched_ack | input | 1 | Scheduler took the request |
| kern_done | output | 1 | Kernel finished pulse |
| kern_done_pkt | output | PW | Packet handle of the finished kernel |
| kern_done_qid | output | QW | Queue number of the finished kernel |
| mem_req_vld | output | 1 | Memory request valid |
| mem_req_rdy | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | AW | Request address |
| mem_req_wdata | output | 64 | Write data |
| mem_rsp_vld | input | 1 | Read response valid |
| mem_rsp_rdata | input | 64 | Read response data |
| err | output | 1 | Sticky protocol error |

## Verification
The assertions assume three things about the memory port: it returns exactly one read response for each accepted read, it never returns a response otherwise, and it never answers before acceptance. They also assume that reset is released away from a clock edge. The bench keeps to this with a one-cycle-latency memory model whose ready line is randomly withheld during the decrement sequence. Its random counter traffic only steps a count within its range and only touches allocated slots, so `err` must stay low there. Illegal codes, underflow, free slots and duplicate allocation are exercised only in separate directed phases after a fresh reset.

// File: rtl/kct_pkg.sv
package kct_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_UP   = 2'b01,
    STEP_BAD  = 2'b10,
    STEP_DOWN = 2'b11
  } step_e;

  typedef enum logic [1:0] {
    RMW_IDLE,
    RMW_RD,
    RMW_WAIT,
    RMW_WR
  } rmw_st_e;
endpackage

// File: rtl/kct_table.sv
module kct_table
  import kct_pkg::*;
#(
  parameter int NK  = 4,
  parameter int CW  = 6,
  parameter int WGW = 12,
  parameter int AW  = 32,
  parameter int PW  = 32,
  parameter int QW  = 4,
  localparam int IDW = $clog2(NK)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc_vld_i,
  input  logic [IDW-1:0] alloc_id_i,
  input  logic [WGW-1:0] alloc_total_i,
  input  logic [AW-1:0]  alloc_sig_i,
  input  logic [PW-1:0]  alloc_pkt_i,
  input  logic [QW-1:0]  alloc_qid_i,
  input  logic           inv_vld_i,
  input  logic [IDW-1:0] inv_id_i,
  input  logic [1:0]     inv_code_i,
  input  logic           wb_vld_i,
  input  logic [IDW-1:0] wb_id_i,
  input  logic [1:0]     wb_code_i,
  input  logic           wg_vld_i,
  input  logic [IDW-1:0] wg_id_i,
  input  logic [IDW-1:0] query_id_i,
  output logic           last_wg_o,
  output logic [NK-1:0]  inv_idle_o,
  output logic           wb_rsp_vld_o,
  output logic           wb_rsp_zero_o,
  output logic           trig_o,
  output logic           done_vld_o,
  output logic [PW-1:0]  done_pkt_o,
  output logic [QW-1:0]  done_qid_o,
  output logic [AW-1:0]  done_sig_o,
  output logic           err_o
);
  logic [NK-1:0]  vld_q, vld_d;
  logic [CW-1:0]  inv_q [NK];
  logic [CW-1:0]  inv_d [NK];
  logic [CW-1:0]  wb_q  [NK];
  logic [CW-1:0]  wb_d  [NK];
  logic [WGW-1:0] cmp_q [NK];
  logic [WGW-1:0] cmp_d [NK];
  logic [WGW-1:0] tot_q [NK];
  logic [WGW-1:0] tot_d [NK];
  logic [AW-1:0]  sig_q [NK];
  logic [AW-1:0]  sig_d [NK];
  logic [PW-1:0]  pkt_q [NK];
  logic [PW-1:0]  pkt_d [NK];
  logic [QW-1:0]  qid_q [NK];
  logic [QW-1:0]  qid_d [NK];
  logic           err_q, err_d, rsp_v_q, rsp_v_d, rsp_z_q, rsp_z_d;
  logic           dn_v_q, dn_v_d;
  logic [PW-1:0]  dn_pkt_q, dn_pkt_d;
  logic [QW-1:0]  dn_qid_q, dn_qid_d;
  logic [AW-1:0]  dn_sig_q, dn_sig_d;
  logic           wg_fin;
  logic [CW-1:0]  wb_new;

  function automatic logic step_ok(input logic [CW-1:0] c, input logic [1:0] code);
    case (step_e'(code))
      STEP_UP:   return c != {CW{1'b1}};
      STEP_DOWN: return c != '0;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic [CW-1:0] step_val(input logic [CW-1:0] c, input logic [1:0] code);
    return (step_e'(code) == STEP_DOWN) ? c - 1'b1 : c + 1'b1;
  endfunction

  assign wg_fin = (cmp_q[wg_id_i] + WGW'(1)) == tot_q[wg_id_i];
  assign wb_new = step_val(wb_q[wb_id_i], wb_code_i);

  always_comb begin
    vld_d = vld_q; inv_d = inv_q; wb_d = wb_q; cmp_d = cmp_q; tot_d = tot_q;
    sig_d = sig_q; pkt_d = pkt_q; qid_d = qid_q; err_d = err_q;
    rsp_v_d = 1'b0; rsp_z_d = rsp_z_q; dn_v_d = 1'b0;
    dn_pkt_d = dn_pkt_q; dn_qid_d = dn_qid_q; dn_sig_d = dn_sig_q; trig_o = 1'b0;
    if (alloc_vld_i) begin
      if (vld_q[alloc_id_i] || alloc_total_i == '0) err_d = 1'b1;
      else begin
        vld_d[alloc_id_i] = 1'b1;
        inv_d[alloc_id_i] = '0;
        wb_d[alloc_id_i]  = '0;
        cmp_d[alloc_id_i] = '0;
        tot_d[alloc_id_i] = alloc_total_i;
        sig_d[alloc_id_i] = alloc_sig_i;
        pkt_d[alloc_id_i] = alloc_pkt_i;
        qid_d[alloc_id_i] = alloc_qid_i;
      end
    end
    if (inv_vld_i) begin
      if (!vld_q[inv_id_i] || !step_ok(inv_q[inv_id_i], inv_code_i)) err_d = 1'b1;
      else begin
        inv_d[inv_id_i] = step_val(inv_q[inv_id_i], inv_code_i);
        if (step_e'(inv_code_i) == STEP_DOWN && inv_q[inv_id_i] == CW'(1)) trig_o = 1'b1;
      end
    end
    if (wb_vld_i) begin
      if (!vld_q[wb_id_i] || !step_ok(wb_q[wb_id_i], wb_code_i)) err_d = 1'b1;
      else begin
        wb_d[wb_id_i] = wb_new;
        rsp_v_d = 1'b1;
        rsp_z_d = (wb_new == '0);
      end
    end
    if (wg_vld_i) begin
      if (!vld_q[wg_id_i]) err_d = 1'b1;
      else begin
        trig_o = 1'b1;
        if (wg_fin) begin
          vld_d[wg_id_i] = 1'b0;
          dn_v_d   = 1'b1;
          dn_pkt_d = pkt_q[wg_id_i];
          dn_qid_d = qid_q[wg_id_i];
          dn_sig_d = sig_q[wg_id_i];
        end else begin
          cmp_d[wg_id_i] = cmp_q[wg_id_i] + WGW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0; err_q <= 1'b0; rsp_v_q <= 1'b0; rsp_z_q <= 1'b0; dn_v_q <= 1'b0;
      dn_pkt_q <= '0; dn_qid_q <= '0; dn_sig_q <= '0;
      for (int k = 0; k < NK; k++) begin
        inv_q[k] <= '0; wb_q[k] <= '0; cmp_q[k] <= '0; tot_q[k] <= '0;
        sig_q[k] <= '0; pkt_q[k] <= '0; qid_q[k] <= '0;
      end
    end else begin
      vld_q <= vld_d; err_q <= err_d; rsp_v_q <= rsp_v_d; rsp_z_q <= rsp_z_d;
      dn_v_q <= dn_v_d;
      if (dn_v_d) begin
        dn_pkt_q <= dn_pkt_d; dn_qid_q <= dn_qid_d; dn_sig_q <= dn_sig_d;
      end
      inv_q <= inv_d; wb_q <= wb_d; cmp_q <= cmp_d; tot_q <= tot_d;
      sig_q <= sig_d; pkt_q <= pkt_d; qid_q <= qid_d;
    end
  end

  for (genvar k = 0; k < NK; k++) begin : g_idle
    assign inv_idle_o[k] = vld_q[k] && inv_q[k] == '0;
  end

  assign last_wg_o     = vld_q[query_id_i] && ((cmp_q[query_id_i] + WGW'(1)) == tot_q[query_id_i]);
  assign wb_rsp_vld_o  = rsp_v_q;
  assign wb_rsp_zero_o = rsp_z_q;
  assign done_vld_o    = dn_v_q;
  assign done_pkt_o    = dn_pkt_q;
  assign done_qid_o    = dn_qid_q;
  assign done_sig_o    = dn_sig_q;
  assign err_o         = err_q;

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) err_q |=> err_q);
  // R4
  wb_rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_v_q |-> $past(wb_vld_i));
  // R6
  wg_count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wg_vld_i && vld_q[wg_id_i] && !wg_fin && !(alloc_vld_i && alloc_id_i == wg_id_i))
    |=> cmp_q[$past(wg_id_i)] == $past(cmp_q[wg_id_i]) + WGW'(1));
  // R7
  done_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wg_vld_i && vld_q[wg_id_i] && wg_fin) |=> dn_v_q && !vld_q[$past(wg_id_i)]);
endmodule

// File: rtl/kct_sched.sv
module kct_sched (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic ack_i,
  output logic req_o,
  output logic pend_o
);
  logic pend_q, pend_d, req_q, req_d, pend_eff;

  always_comb begin
    pend_eff = pend_q && !ack_i;
    req_d    = trig_i && !pend_eff;
    pend_d   = pend_eff || trig_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      req_q  <= req_d;
    end
  end

  assign req_o  = req_q;
  assign pend_o = pend_q;

  // R3
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (pend_q && !ack_i) |=> pend_q);
  // R3
  req_implies_pend_chk: assert property (@(posedge clk) disable iff (!rst_n) req_q |-> pend_q);
endmodule

// File: rtl/kct_sig_rmw.sv
module kct_sig_rmw
  import kct_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  output logic          busy_o,
  output logic          req_vld_o,
  input  logic          req_rdy_i,
  output logic          req_we_o,
  output logic [AW-1:0] req_addr_o,
  output logic [63:0]   req_wdata_o,
  input  logic          rsp_vld_i,
  input  logic [63:0]   rsp_rdata_i
);
  rmw_st_e       st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [63:0]   data_q, data_d;

  always_comb begin
    st_d = st_q; addr_d = addr_q; data_d = data_q;
    case (st_q)
      RMW_IDLE: if (start_i) begin st_d = RMW_RD; addr_d = addr_i; end
      RMW_RD:   if (req_rdy_i) st_d = RMW_WAIT;
      RMW_WAIT: if (rsp_vld_i) begin st_d = RMW_WR; data_d = rsp_rdata_i - 64'd1; end
      RMW_WR:   if (req_rdy_i) st_d = RMW_IDLE;
      default:  st_d = RMW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RMW_IDLE;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == RMW_IDLE) addr_q <= addr_d;
      if (st_q == RMW_WAIT) data_q <= data_d;
    end
  end

  assign busy_o      = st_q != RMW_IDLE;
  assign req_vld_o   = st_q == RMW_RD || st_q == RMW_WR;
  assign req_we_o    = st_q == RMW_WR;
  assign req_addr_o  = addr_q;
  assign req_wdata_o = data_q;

  // R8
  req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld_o && !req_rdy_i) |=> req_vld_o && $stable(req_addr_o) && $stable(req_we_o));
  // R8
  write_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld_i && st_q == RMW_WAIT) |=> req_vld_o && req_we_o);
endmodule

// File: rtl/kern_track.sv
module kern_track #(
  parameter int NK  = 4,
  parameter int CW  = 6,
  parameter int WGW = 12,
  parameter int AW  = 32,
  parameter int PW  = 32,
  parameter int QW  = 4,
  localparam int IDW = $clog2(NK)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc_vld,
  input  logic [IDW-1:0] alloc_id,
  input  logic [WGW-1:0] alloc_wg_total,
  input  logic [AW-1:0]  alloc_sig_addr,
  input  logic [PW-1:0]  alloc_pkt,
  input  logic [QW-1:0]  alloc_qid,
  input  logic           inv_vld,
  input  logic [IDW-1:0] inv_id,
  input  logic [1:0]     inv_code,
  input  logic           wb_vld,
  input  logic [IDW-1:0] wb_id,
  input  logic [1:0]     wb_code,
  output logic           wb_rsp_vld,
  output logic           wb_rsp_zero,
  input  logic [IDW-1:0] query_id,
  output logic           last_wg,
  input  logic           wg_done_vld,
  input  logic [IDW-1:0] wg_done_id,
  output logic           wg_done_rdy,
  output logic [NK-1:0]  inv_idle,
  output logic           sched_req,
  output logic           sched_pend,
  input  logic           sched_ack,
  output logic           kern_done,
  output logic [PW-1:0]  kern_done_pkt,
  output logic [QW-1:0]  kern_done_qid,
  output logic           mem_req_vld,
  input  logic           mem_req_rdy,
  output logic           mem_req_we,
  output logic [AW-1:0]  mem_req_addr,
  output logic [63:0]    mem_req_wdata,
  input  logic           mem_rsp_vld,
  input  logic [63:0]    mem_rsp_rdata,
  output logic           err
);
  logic          trig, rmw_busy, rmw_start, wg_take;
  logic [AW-1:0] done_sig;

  assign rmw_start   = kern_done && done_sig != '0;
  assign wg_done_rdy = !(rmw_busy || rmw_start);
  assign wg_take     = wg_done_vld && wg_done_rdy;

  kct_table #(.NK(NK), .CW(CW), .WGW(WGW), .AW(AW), .PW(PW), .QW(QW)) u_table (
    .clk, .rst_n,
    .alloc_vld_i(alloc_vld), .alloc_id_i(alloc_id), .alloc_total_i(alloc_wg_total),
    .alloc_sig_i(alloc_sig_addr), .alloc_pkt_i(alloc_pkt), .alloc_qid_i(alloc_qid),
    .inv_vld_i(inv_vld), .inv_id_i(inv_id), .inv_code_i(inv_code),
    .wb_vld_i(wb_vld), .wb_id_i(wb_id), .wb_code_i(wb_code),
    .wg_vld_i(wg_take), .wg_id_i(wg_done_id), .query_id_i(query_id),
    .last_wg_o(last_wg), .inv_idle_o(inv_idle),
    .wb_rsp_vld_o(wb_rsp_vld), .wb_rsp_zero_o(wb_rsp_zero), .trig_o(trig),
    .done_vld_o(kern_done), .done_pkt_o(kern_done_pkt), .done_qid_o(kern_done_qid),
    .done_sig_o(done_sig), .err_o(err)
  );

  kct_sched u_sched (
    .clk, .rst_n, .trig_i(trig), .ack_i(sched_ack), .req_o(sched_req), .pend_o(sched_pend)
  );

  kct_sig_rmw #(.AW(AW)) u_rmw (
    .clk, .rst_n, .start_i(rmw_start), .addr_i(done_sig), .busy_o(rmw_busy),
    .req_vld_o(mem_req_vld), .req_rdy_i(mem_req_rdy), .req_we_o(mem_req_we),
    .req_addr_o(mem_req_addr), .req_wdata_o(mem_req_wdata),
    .rsp_vld_i(mem_rsp_vld), .rsp_rdata_i(mem_rsp_rdata)
  );

  // R9
  rmw_starts_chk: assert property (@(posedge clk) disable iff (!rst_n) rmw_start |=> rmw_busy);
  // R8
  no_sig_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kern_done && done_sig == '0 && !rmw_busy) |-> !mem_req_vld);
endmodule

// File: tb/kern_track_test.sv
module kern_track_test;
  localparam int NK = 4, CW = 6, WGW = 12, AW = 32, PW = 32, QW = 4, IDW = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n;
  logic           alloc_vld, inv_vld, wb_vld, wg_done_vld, sched_ack, mem_req_rdy, mem_rsp_vld;
  logic [IDW-1:0] alloc_id, inv_id, wb_id, query_id, wg_done_id;
  logic [WGW-1:0] alloc_wg_total;
  logic [AW-1:0]  alloc_sig_addr, mem_req_addr;
  logic [PW-1:0]  alloc_pkt, kern_done_pkt;
  logic [QW-1:0]  alloc_qid, kern_done_qid;
  logic [1:0]     inv_code, wb_code;
  logic           wb_rsp_vld, wb_rsp_zero, last_wg, wg_done_rdy, sched_req, sched_pend;
  logic           kern_done, mem_req_vld, mem_req_we, err;
  logic [NK-1:0]  inv_idle;
  logic [63:0]    mem_req_wdata, mem_rsp_rdata;

  kern_track uut (.*);

  int n_chk = 0, n_fail = 0, done_cnt = 0, req_cnt = 0, wr_cnt = 0;
  logic [AW-1:0] last_waddr;
  logic [63:0]   mem [8];
  logic          stall_en = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rsp_vld <= 1'b0;
      mem_rsp_rdata <= '0;
      for (int i = 0; i < 8; i++) mem[i] <= 64'h100 + 64'(i);
    end else begin
      mem_rsp_vld <= 1'b0;
      if (kern_done) done_cnt <= done_cnt + 1;
      if (mem_req_vld && mem_req_rdy) begin
        req_cnt <= req_cnt + 1;
        if (mem_req_we) begin
          mem[mem_req_addr[5:3]] <= mem_req_wdata;
          wr_cnt <= wr_cnt + 1;
          last_waddr <= mem_req_addr;
        end else begin
          mem_rsp_vld <= 1'b1;
          mem_rsp_rdata <= mem[mem_req_addr[5:3]];
        end
      end
    end
  end

  always @(negedge clk) mem_req_rdy <= stall_en ? 1'($urandom % 2) : 1'b1;

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    alloc_vld = 0; inv_vld = 0; wb_vld = 0; wg_done_vld = 0;
  endtask

  task automatic do_reset();
    alloc_vld = 0; inv_vld = 0; wb_vld = 0; wg_done_vld = 0; sched_ack = 0;
    alloc_id = 0; inv_id = 0; wb_id = 0; query_id = 0; wg_done_id = 0;
    alloc_wg_total = 0; alloc_sig_addr = 0; alloc_pkt = 0; alloc_qid = 0;
    inv_code = 0; wb_code = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic alloc(int id, int tot, logic [AW-1:0] sig, logic [PW-1:0] pkt, logic [QW-1:0] q);
    alloc_vld = 1; alloc_id = IDW'(id); alloc_wg_total = WGW'(tot);
    alloc_sig_addr = sig; alloc_pkt = pkt; alloc_qid = q;
    tick();
  endtask

  task automatic inv_op(int id, logic [1:0] code);
    inv_vld = 1; inv_id = IDW'(id); inv_code = code; tick();
  endtask

  task automatic wb_op(int id, logic [1:0] code);
    wb_vld = 1; wb_id = IDW'(id); wb_code = code; tick();
  endtask

  task automatic wg_op(int id);
    wg_done_vld = 1; wg_done_id = IDW'(id); tick();
  endtask

  int            inv_m [NK];
  int            wb_m  [NK];
  logic [NK-1:0] exp_idle;

  initial begin
    void'($urandom(32'h5eed));
    do_reset();
    // R11 reset state
    chk("R11 inv_idle", inv_idle, 0);
    chk("R11 err", err, 0);
    chk("R11 sched_req", sched_req, 0);
    chk("R11 sched_pend", sched_pend, 0);
    chk("R11 kern_done", kern_done, 0);
    chk("R11 mem_req_vld", mem_req_vld, 0);
    chk("R11 wg_done_rdy", wg_done_rdy, 1);

    alloc(0, 3, 32'h18, 32'hA0, 4'd5);
    alloc(1, 1, 32'h0, 32'hB1, 4'd2);
    chk("R2 idle after alloc", inv_idle, 4'b0011);
    inv_op(0, 2'b01);
    chk("R2 idle after inc", inv_idle, 4'b0010);
    chk("R3 no req on inc", sched_req, 0);
    inv_op(0, 2'b11);
    chk("R2 idle after dec", inv_idle, 4'b0011);
    chk("R3 req on drain", sched_req, 1);
    chk("R3 pend set", sched_pend, 1);
    inv_op(1, 2'b01);
    inv_op(1, 2'b11);
    chk("R3 no req while pending", sched_req, 0);
    chk("R3 still pending", sched_pend, 1);
    sched_ack = 1; tick(); sched_ack = 0;
    chk("R3 ack clears", sched_pend, 0);

    wb_op(0, 2'b01);
    chk("R4 rsp vld", wb_rsp_vld, 1);
    chk("R4 not zero", wb_rsp_zero, 0);
    wb_op(0, 2'b11);
    chk("R4 zero", wb_rsp_zero, 1);

    query_id = 0; #1;
    chk("R5 first", last_wg, 0);
    wg_op(0);
    chk("R3 req on wg", sched_req, 1);
    chk("R5 after one", last_wg, 0);
    sched_ack = 1; tick(); sched_ack = 0;
    wg_op(0);
    chk("R6 count two -> last", last_wg, 1);
    chk("R7 not yet done", done_cnt, 0);

    stall_en = 1;
    wg_done_vld = 1; wg_done_id = 0; tick();
    chk("R7 done pulse", kern_done, 1);
    chk("R7 pkt", kern_done_pkt, 32'hA0);
    chk("R7 qid", kern_done_qid, 5);
    chk("R9 rdy low", wg_done_rdy, 0);
    wg_done_vld = 1; wg_done_id = 1; tick();
    for (int i = 0; i < 60 && wr_cnt == 0; i++) tick();
    stall_en = 0;
    tick();
    chk("R8 write addr", last_waddr, 32'h18);
    chk("R8 decremented", mem[3], 64'h102);
    chk("R8 two requests", req_cnt, 2);
    chk("R9 ignored completion", done_cnt, 1);
    query_id = 1; #1;
    chk("R9 slot1 untouched", last_wg, 1);
    chk("R9 rdy back", wg_done_rdy, 1);

    wg_op(1);
    chk("R7 done slot1", kern_done, 1);
    chk("R7 pkt slot1", kern_done_pkt, 32'hB1);
    chk("R7 qid slot1", kern_done_qid, 2);
    repeat (5) tick();
    chk("R8 no mem without signal", req_cnt, 2);
    query_id = 0; #1;
    chk("R5 freed slot", last_wg, 0);
    chk("R10 no err so far", err, 0);

    // random counter traffic, R1 R2 R3 R4
    do_reset();
    for (int k = 0; k < NK; k++) begin
      alloc(k, 100, 32'h0, PW'(k), QW'(k));
      inv_m[k] = 0; wb_m[k] = 0;
    end
    sched_ack = 1;
    for (int n = 0; n < 300; n++) begin
      int  id;
      bool_blk: begin
        logic up, to_zero;
        id = int'($urandom % NK);
        if ($urandom % 2 == 0) begin
          up = (inv_m[id] == 0) || (inv_m[id] < 63 && $urandom % 2 == 0);
          to_zero = !up && inv_m[id] == 1;
          inv_m[id] = up ? inv_m[id] + 1 : inv_m[id] - 1;
          inv_op(id, up ? 2'b01 : 2'b11);
          for (int k = 0; k < NK; k++) exp_idle[k] = (inv_m[k] == 0);
          chk("R2 random idle", inv_idle, exp_idle);
          chk("R3 random req", sched_req, to_zero);
        end else begin
          up = (wb_m[id] == 0) || (wb_m[id] < 63 && $urandom % 2 == 0);
          wb_m[id] = up ? wb_m[id] + 1 : wb_m[id] - 1;
          wb_op(id, up ? 2'b01 : 2'b11);
          chk("R4 random rsp", wb_rsp_vld, 1);
          chk("R4 random zero", wb_rsp_zero, wb_m[id] == 0);
        end
      end
    end
    sched_ack = 0;
    chk("R1 legal steps no err", err, 0);

    // error cases
    do_reset();
    alloc(2, 2, 32'h0, 32'h1, 4'd1);
    inv_op(2, 2'b01);
    inv_op(2, 2'b10);
    chk("R1 bad code err", err, 1);
    chk("R10 count kept", inv_idle, 4'b0000);
    inv_op(2, 2'b11);
    chk("R10 count was one", inv_idle, 4'b0100);
    do_reset();
    wb_op(3, 2'b01);
    chk("R10 free slot err", err, 1);
    chk("R10 no rsp", wb_rsp_vld, 0);
    do_reset();
    alloc(0, 2, 32'h0, 32'h1, 4'd1);
    inv_op(0, 2'b11);
    chk("R1 underflow err", err, 1);
    chk("R1 underflow no req", sched_req, 0);
    chk("R1 underflow idle kept", inv_idle, 4'b0001);
    do_reset();
    alloc(1, 2, 32'h0, 32'h1, 4'd1);
    alloc(1, 5, 32'h0, 32'h1, 4'd1);
    chk("R10 double alloc err", err, 1);
    wg_op(1);
    query_id = 1; #1;
    chk("R10 total kept", last_wg, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule